// File: doc/BRIEF.md
# Self-Timed Word-Program Controller for a Non-Volatile Array

This block sits between a 32-bit bus and an on-chip non-volatile array. The array is modelled here as a register file. The bus has two address windows. The register window holds configuration and status. The memory window gives direct word access to the array. All accesses are 32-bit words on a 4-byte stride.

When auto-programming is enabled, one accepted word write to the memory window starts an erase/program cycle with no further command. The cycle is timed by a prescaled tick derived from the bus clock. While it runs, a busy output is high. The new word reaches the array only when the cycle ends. At that point a sticky end-of-program flag is raised and mirrored on a level interrupt output. Software clears the flag through a separate write-one-to-clear location.

The array can be powered down, and a wake-up delay follows each power-up. The last page holds initialisation data and refuses every write. Memory accesses that cannot be honoured are not performed and return an error response in the same cycle.

Top module: `eac_autoprog_ctrl`

## Requirements
- R1: After reset, busy and irq are 0. The register window reads auto-program 0, divider 0, power-down 1 and status 0. Array word i holds INIT_BASE XOR i.
- R2: The register window decodes three read/write locations: byte offset 0x00C (bit 0 enables auto-programming), 0x014 (the low DIV_W bits hold the divider) and 0x018 (bit 0 = 1 is power-down). Offset 0xFE0 reads the end-of-program flag in bit 2 and 0 in all other bits. Every other offset, including 0xFE8, reads 0, and writes to unmapped offsets change nothing. Register-window accesses never return an error.
- R3: A memory-window read returns, in the same cycle and with no error, the word at index addr[MEM_AW-1:2]. This holds when the array is powered up, awake and not busy.
- R4: A write of 0 to offset 0x018 while powered down starts a wake-up delay. For the next WAKE_CYCLES cycles every memory-window access returns an error.
- R5: While powered down, every memory-window access returns an error with read data 0.
- R6: A memory write is accepted when auto-programming is on and the array is awake, idle and outside the last page. An accepted write raises busy on the next cycle. Busy stays high for exactly PROG_TICKS*(divider+1) cycles.
- R7: On the clock edge where busy falls, the written word is stored and the end-of-program flag sets. irq follows the flag level.
- R8: While busy, every memory-window access returns an error, and a rejected write leaves the array unchanged.
- R9: A write to the last page (word index at or above (MEM_BYTES-PAGE_BYTES)/4) returns an error, starts no cycle and leaves the stored word unchanged.
- R10: With auto-programming off, a memory write returns an error and starts no cycle.
- R11: The flag stays set until a write to offset 0xFE8 with bit 2 = 1 clears it. Such a write with bit 2 = 0 has no effect. A clear that coincides with the end of a cycle loses, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_mem | input | 1 | 1 = memory window, 0 = register window |
| bus_addr | input | ADDR_W | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when not a successful read |
| bus_err | output | 1 | Error response for the current access |
| busy | output | 1 | Erase/program cycle in progress |
| irq | output | 1 | Level copy of the end-of-program flag |

## Verification
A stale program counter or prescaler shows up at once in the length of the busy pulse. It also shows in the cycle where irq rises, so a one-tick slip is caught on the edge where busy falls. A wrong pending address or data register stays hidden until the word is read back after the cycle, which the bench does directly. A lost wake-up count or power-down bit shows up in the error response of the very next memory access. The bench probes memory accesses every cycle through those windows.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int unsigned OFF_AUTO  = 32'h00C;
  localparam int unsigned OFF_DIV   = 32'h014;
  localparam int unsigned OFF_PWR   = 32'h018;
  localparam int unsigned OFF_STAT  = 32'hFE0;
  localparam int unsigned OFF_CLR   = 32'hFE8;
  localparam int unsigned STAT_BIT  = 2;

  function automatic logic [31:0] init_word(input logic [31:0] base, input int unsigned idx);
    return base ^ idx;
  endfunction
endpackage

// File: rtl/eac_clkdiv.sv
module eac_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == div);

  always_comb begin
    pre_d = pre_q;
    if (!run || tick) pre_d = '0;
    else              pre_d = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/eac_prog_timer.sv
module eac_prog_timer #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign busy = busy_q;
  assign done = busy_q && tick && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = CNT_W'(TICKS);
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/eac_array.sv
module eac_array #(
  parameter int unsigned WORDS     = 128,
  parameter int unsigned AW        = 7,
  parameter logic [31:0] INIT_BASE = 32'hC0DE0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  import eac_pkg::*;

  logic [31:0] cell_q [WORDS];
  logic [31:0] seed   [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_seed
    assign seed[g] = init_word(INIT_BASE, g);
  end

  assign rdata = cell_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cell_q[i] <= seed[i];
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/eac_autoprog_ctrl.sv
module eac_autoprog_ctrl #(
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned PAGE_BYTES  = 128,
  parameter int unsigned PROG_TICKS  = 3,
  parameter int unsigned WAKE_CYCLES = 6,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [31:0] INIT_BASE   = 32'hC0DE0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_mem,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              busy,
  output logic              irq
);
  import eac_pkg::*;

  localparam int unsigned WORDS     = MEM_BYTES / 4;
  localparam int unsigned MEM_AW    = $clog2(MEM_BYTES);
  localparam int unsigned WORD_AW   = MEM_AW - 2;
  localparam int unsigned LAST_WORD = (MEM_BYTES - PAGE_BYTES) / 4;
  localparam int unsigned WK_W      = $clog2(WAKE_CYCLES + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // state
  logic               auto_q,  auto_d;
  logic [DIV_W-1:0]   div_q,   div_d;
  logic               pd_q,    pd_d;
  logic               flag_q,  flag_d;
  logic [WK_W-1:0]    wake_q,  wake_d;
  logic [WORD_AW-1:0] pidx_q,  pidx_d;
  logic [31:0]        pdat_q,  pdat_d;

  // decode
  logic               mem_rd, mem_wr, reg_rd, reg_wr;
  logic [WORD_AW-1:0] widx;
  logic               awake, mem_ok, in_last, start, clr_hit;
  logic               tick, done, busy_w;
  logic [31:0]        arr_rdata, reg_rdata;

  assign widx    = bus_addr[MEM_AW-1:2];
  assign mem_rd  = bus_req &&  bus_mem && !bus_we;
  assign mem_wr  = bus_req &&  bus_mem &&  bus_we;
  assign reg_rd  = bus_req && !bus_mem && !bus_we;
  assign reg_wr  = bus_req && !bus_mem &&  bus_we;
  assign awake   = !pd_q && (wake_q == '0);
  assign mem_ok  = awake && !busy_w;
  assign in_last = (widx >= WORD_AW'(LAST_WORD));
  assign start   = mem_wr && mem_ok && auto_q && !in_last;
  assign clr_hit = reg_wr && (bus_addr == ADDR_W'(OFF_CLR)) && bus_wdata[STAT_BIT];

  eac_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy_w),
    .div   (div_q),
    .tick  (tick)
  );

  eac_prog_timer #(.TICKS(PROG_TICKS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .tick  (tick),
    .busy  (busy_w),
    .done  (done)
  );

  eac_array #(.WORDS(WORDS), .AW(WORD_AW), .INIT_BASE(INIT_BASE)) u_arr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (done),
    .waddr (pidx_q),
    .wdata (pdat_q),
    .raddr (widx),
    .rdata (arr_rdata)
  );

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_AUTO))      reg_rdata[0] = auto_q;
    else if (bus_addr == ADDR_W'(OFF_DIV))  reg_rdata[DIV_W-1:0] = div_q;
    else if (bus_addr == ADDR_W'(OFF_PWR))  reg_rdata[0] = pd_q;
    else if (bus_addr == ADDR_W'(OFF_STAT)) reg_rdata[STAT_BIT] = flag_q;
  end

  // bus response
  always_comb begin
    bus_rdata = '0;
    bus_err   = 1'b0;
    if (mem_rd) begin
      if (mem_ok) bus_rdata = arr_rdata;
      else        bus_err   = 1'b1;
    end else if (mem_wr) begin
      bus_err = !start;
    end else if (reg_rd) begin
      bus_rdata = reg_rdata;
    end
  end

  // next state
  always_comb begin
    auto_d = auto_q;
    div_d  = div_q;
    pd_d   = pd_q;
    wake_d = wake_q;
    pidx_d = pidx_q;
    pdat_d = pdat_q;
    flag_d = flag_q;

    if (wake_q != '0) wake_d = wake_q - WK_W'(1);

    if (reg_wr) begin
      if (bus_addr == ADDR_W'(OFF_AUTO)) auto_d = bus_wdata[0];
      if (bus_addr == ADDR_W'(OFF_DIV))  div_d  = bus_wdata[DIV_W-1:0];
      if (bus_addr == ADDR_W'(OFF_PWR)) begin
        pd_d = bus_wdata[0];
        if (pd_q && !bus_wdata[0]) wake_d = WK_W'(WAKE_CYCLES);
      end
    end

    if (start) begin
      pidx_d = widx;
      pdat_d = bus_wdata;
    end

    if (clr_hit) flag_d = 1'b0;
    if (done)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      auto_q <= 1'b0;
      div_q  <= '0;
      pd_q   <= 1'b1;
      flag_q <= 1'b0;
      wake_q <= '0;
      pidx_q <= '0;
      pdat_q <= '0;
    end else begin
      auto_q <= auto_d;
      div_q  <= div_d;
      pd_q   <= pd_d;
      flag_q <= flag_d;
      wake_q <= wake_d;
      pidx_q <= pidx_d;
      pdat_q <= pdat_d;
    end
  end

  assign busy = busy_w;
  assign irq  = flag_q;
endmodule

// File: rtl/eac_checker.sv
module eac_checker #(
  parameter int unsigned MEM_BYTES  = 512,
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned ADDR_W     = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_mem,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_bit2,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              busy,
  input logic              irq,
  input logic              pd_q
);
  import eac_pkg::*;
  localparam int unsigned MEM_AW    = $clog2(MEM_BYTES);
  localparam int unsigned LAST_WORD = (MEM_BYTES - PAGE_BYTES) / 4;

  logic clr_wr;
  assign clr_wr = bus_req && bus_we && !bus_mem && (bus_addr == ADDR_W'(OFF_CLR)) && wr_bit2;

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_req && bus_mem |-> bus_err);

  p_pd_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q && bus_req && bus_mem |-> bus_err && (bus_rdata == 32'h0));

  p_last_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_mem && bus_we && (32'(bus_addr[MEM_AW-1:2]) >= LAST_WORD) |-> bus_err);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_mem && bus_we && !bus_err |=> busy);

  p_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_wr |=> irq);
endmodule

bind eac_autoprog_ctrl eac_checker #(
  .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_mem(bus_mem),
  .bus_addr(bus_addr), .wr_bit2(bus_wdata[2]), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .busy(busy), .irq(irq), .pd_q(pd_q)
);

// File: tb/eac_autoprog_ctrl_tb.sv
module eac_autoprog_ctrl_tb;
  localparam int MEM_BYTES = 512;
  localparam int PAGE_BYTES = 128;
  localparam int TICKS = 3;
  localparam int WAKE = 6;
  localparam int WORDS = MEM_BYTES / 4;
  localparam int LAST = (MEM_BYTES - PAGE_BYTES) / 4;
  localparam logic [31:0] BASE = 32'hC0DE0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, mem = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err, busy, irq;

  always #10 clk = ~clk;

  eac_autoprog_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .PROG_TICKS(TICKS),
                      .WAKE_CYCLES(WAKE), .INIT_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_mem(mem), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .busy(busy), .irq(irq));

  // behavioural reference state
  int unsigned m_mem [WORDS];
  int m_auto, m_div, m_pd, m_flag, m_wake, m_left, p_idx;
  int unsigned p_data;
  int n_vec = 0, n_bad = 0;

  task automatic cycle(input bit r, input bit w, input bit m, input int a, input int unsigned d,
                       input string tag);
    int unsigned e_rd;
    bit e_err, ok, acc, done;
    int idx;
    req = r; we = w; mem = m; addr = 12'(a); wdata = d;
    @(negedge clk);
    idx = (a % MEM_BYTES) / 4;
    ok = (m_pd == 0) && (m_wake == 0) && (m_left == 0);
    acc = 0; e_rd = 0; e_err = 0;
    if (r && m && !w) begin
      e_err = !ok;
      if (ok) e_rd = m_mem[idx];
    end else if (r && m && w) begin
      acc = ok && (m_auto != 0) && (idx < LAST);
      e_err = !acc;
    end else if (r && !m && !w) begin
      case (a)
        'h00C: e_rd = m_auto;
        'h014: e_rd = m_div;
        'h018: e_rd = m_pd;
        'hFE0: e_rd = m_flag << 2;
        default: e_rd = 0;
      endcase
    end
    n_vec++;
    if (rdata !== e_rd || err !== e_err || busy !== (m_left > 0) || irq !== (m_flag != 0)) begin
      n_bad++;
      $display("FAIL %s: rdata=%h err=%b busy=%b irq=%b expected rdata=%h err=%b busy=%b irq=%b",
               tag, rdata, err, busy, irq, e_rd, e_err, m_left > 0, m_flag != 0);
    end
    // advance model
    done = (m_left == 1);
    if (m_left > 0) m_left--;
    if (done) m_mem[p_idx] = p_data;
    if (r && !m && w && a == 'h018 && d[0] == 1'b0 && m_pd == 1) m_wake = WAKE;
    else if (m_wake > 0) m_wake--;
    if (r && !m && w) begin
      if (a == 'h00C) m_auto = d[0];
      if (a == 'h014) m_div = d[7:0];
      if (a == 'h018) m_pd = d[0];
      if (a == 'hFE8 && d[2]) m_flag = 0;
    end
    if (done) m_flag = 1;
    if (acc) begin
      m_left = TICKS * (m_div + 1);
      p_idx = idx;
      p_data = d;
    end
    @(posedge clk);
    #1;
    req = 0; we = 0; mem = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, tag);
  endtask

  task automatic wait_done(input string tag);
    while (m_left > 0) cycle(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) m_mem[i] = BASE ^ i;
    m_auto = 0; m_div = 0; m_pd = 1; m_flag = 0; m_wake = 0; m_left = 0; p_idx = 0; p_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4, "R1");
    // R1 reset values
    cycle(1, 0, 0, 'h00C, 0, "R1");
    cycle(1, 0, 0, 'h014, 0, "R1");
    cycle(1, 0, 0, 'h018, 0, "R1");
    cycle(1, 0, 0, 'hFE0, 0, "R1");
    // R5 powered down
    cycle(1, 0, 1, 20, 0, "R5");
    cycle(1, 1, 1, 24, 32'h1111, "R5");
    // R2 register map
    cycle(1, 1, 0, 'h014, 4, "R2");
    cycle(1, 1, 0, 'h00C, 1, "R2");
    cycle(1, 0, 0, 'h014, 0, "R2");
    cycle(1, 0, 0, 'h00C, 0, "R2");
    cycle(1, 1, 0, 'h100, 32'hFFFFFFFF, "R2");
    cycle(1, 0, 0, 'h100, 0, "R2");
    cycle(1, 0, 0, 'hFE8, 0, "R2");
    // R4 wake delay, then R3 reads
    cycle(1, 1, 0, 'h018, 0, "R4");
    for (int i = 0; i < WAKE + 2; i++) cycle(1, 0, 1, 4 * i, 0, "R4");
    cycle(1, 0, 1, 0, 0, "R3");
    cycle(1, 0, 1, 4 * 95, 0, "R3");
    cycle(1, 0, 1, 4 * 127, 0, "R3");
    cycle(1, 0, 1, 4 * 33 + 2, 0, "R3");
    // R6/R7/R8 program with divider 4
    cycle(1, 1, 1, 40, 32'hDEADBEEF, "R6");
    cycle(1, 1, 1, 44, 32'h12345678, "R8");
    cycle(1, 0, 1, 40, 0, "R8");
    cycle(1, 1, 0, 'h00C, 1, "R8");
    while (m_left > 0) cycle(1, 1, 1, 44, 32'hABCDEF01, "R8");
    cycle(1, 0, 1, 40, 0, "R7");
    cycle(1, 0, 1, 44, 0, "R8");
    cycle(1, 0, 0, 'hFE0, 0, "R7");
    // R11 clear behaviour
    cycle(1, 1, 0, 'hFE8, 32'hFFFFFFFB, "R11");
    cycle(1, 0, 0, 'hFE0, 0, "R11");
    cycle(1, 1, 0, 'hFE8, 4, "R11");
    cycle(1, 0, 0, 'hFE0, 0, "R11");
    // R9 last page protected
    cycle(1, 1, 1, 4 * LAST, 32'h0BAD0BAD, "R9");
    cycle(1, 1, 1, 4 * 127, 32'h0BAD0BAD, "R9");
    idle(2, "R9");
    cycle(1, 0, 1, 4 * LAST, 0, "R9");
    cycle(1, 0, 1, 4 * 127, 0, "R9");
    // R10 auto-program off
    cycle(1, 1, 0, 'h00C, 0, "R10");
    cycle(1, 1, 1, 48, 32'h5A5A5A5A, "R10");
    idle(2, "R10");
    cycle(1, 0, 1, 48, 0, "R10");
    cycle(1, 1, 0, 'h00C, 1, "R10");
    // R6 divider 0, clear colliding with end (R11)
    cycle(1, 1, 0, 'h014, 0, "R6");
    cycle(1, 1, 1, 80, 32'hCAFEF00D, "R6");
    while (m_left > 1) cycle(0, 0, 0, 0, 0, "R6");
    cycle(1, 1, 0, 'hFE8, 4, "R11");
    cycle(1, 0, 0, 'hFE0, 0, "R11");
    cycle(1, 0, 1, 80, 0, "R7");
    cycle(1, 1, 0, 'hFE8, 4, "R11");
    // divider 2 back-to-back programs
    cycle(1, 1, 0, 'h014, 2, "R6");
    cycle(1, 1, 1, 0, 32'h00000001, "R6");
    wait_done("R6");
    cycle(1, 1, 1, 4 * (LAST - 1), 32'h80000000, "R6");
    wait_done("R6");
    cycle(1, 0, 1, 0, 0, "R7");
    cycle(1, 0, 1, 4 * (LAST - 1), 0, "R7");
    // R5 power down again
    cycle(1, 1, 0, 'h018, 1, "R5");
    cycle(1, 0, 1, 0, 0, "R5");
    cycle(1, 1, 1, 8, 32'h77, "R5");
    cycle(1, 0, 0, 'h018, 0, "R5");
    idle(3, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule